// File: doc/BRIEF.md
# Multiply-Add Execution Unit

The block is the integer multiply-add unit of an execute stage. Each accepted request carries three 64-bit operands A, B and C, a 6-bit extended-opcode selector and a 5-bit destination index. The unit forms the full 128-bit product of A and B and adds C, widened to 128 bits by sign or zero extension as the variant requires. It then drives one or two register-file write ports, each with its own index and data.

Four selector values are decoded. Two of them write the high half of the sum and one writes the low half, each to the destination index. The fourth, the dual-destination variant, writes the low half to the destination index and the high half to the next index up. The unit has no internal stall. A request is accepted in every cycle that reset is not asserted, and its result appears a fixed two cycles later. Illegal selectors, and dual writes whose second index would wrap, raise a flag instead of writing.

Top module: `madd_unit`

## Requirements
- R1: Selector 110000 is signed-high (A, B and C signed, high 64 bits of the sum to the destination index). Selector 110001 is unsigned-high. Selector 110010 is dual. Selector 110011 is low.
- R2: Dual (110010) adds the unsigned 128-bit product of A and B to zero-extended C. Port 0 writes the low 64 bits to index RT. Port 1 writes the high 64 bits to index RT+1. Both enables assert in the same cycle.
- R3: Unsigned-high (110001) writes only the high 64 bits of the unsigned sum through port 0 to RT. Port 1 stays idle.
- R4: Low (110011) writes, through port 0 to RT, the low 64 bits of A times B plus sign-extended C. Port 1 stays idle.
- R5: Signed-high (110000) writes, through port 0 to RT, the high 64 bits of the two's-complement sum of A times B plus C. This holds for all-ones operands and for the most negative value.
- R6: Any selector other than 110000 to 110011 raises `illegal` for one cycle, with both write enables low.
- R7: Dual with RT = 31 raises `bad_index` for one cycle and performs no write on either port. The other variants write normally to index 31.
- R8: Results, flags and enables appear exactly two rising edges after acceptance, for one cycle only. Nothing is asserted in a cycle that has no request two edges earlier.
- R9: While `rst` is high, `req_ready` is low and all write enables and flags are low.
- R10: Requests in consecutive cycles are each accepted and produce results in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept (high out of reset) |
| req_xo | input | 6 | Extended-opcode selector |
| req_a | input | 64 | Operand A |
| req_b | input | 64 | Operand B |
| req_c | input | 64 | Addend C |
| req_rt | input | 5 | Destination index |
| wr0_en | output | 1 | Port 0 write enable |
| wr0_idx | output | 5 | Port 0 register index |
| wr0_data | output | 64 | Port 0 write data |
| wr1_en | output | 1 | Port 1 write enable |
| wr1_idx | output | 5 | Port 1 register index |
| wr1_data | output | 64 | Port 1 write data |
| illegal | output | 1 | Unrecognised selector |
| bad_index | output | 1 | Dual write whose second index would wrap |

## Verification
Two cases are the hardest to reach from the ports. The first is a sign-sensitive carry into the high half: the signed-high result differs from the unsigned one only when the operands' top bits and the addend's extension interact. The vector table therefore drives all-ones operands, the most negative value squared, and a most-negative times one with an all-ones addend, and compares each against an independent 128-bit model. The second is the wrap case, where RT is 31 under the dual variant. The bench issues it directly and also issues a non-dual variant at index 31, to show that only the dual form is suppressed. Back-to-back issue checks that results from consecutive requests do not bleed into one another.

// File: rtl/madd_pkg.sv
package madd_pkg;
    localparam int XLEN  = 64;
    localparam int WIDE  = 2 * XLEN;
    localparam int REGW  = 5;
    localparam int XOW   = 6;
    localparam int NPORT = 2;

    typedef enum logic [2:0] {
        OP_HD  = 3'd0,
        OP_HDU = 3'd1,
        OP_ED  = 3'd2,
        OP_LD  = 3'd3,
        OP_ILL = 3'd4
    } op_e;

    typedef struct packed {
        logic hi_to_rt;
        logic dual;
        logic sgn_ab;
        logic sgn_c;
    } ctl_t;

    typedef struct packed {
        logic            vld;
        logic            ill;
        ctl_t            ctl;
        logic [WIDE-1:0] a;
        logic [WIDE-1:0] b;
        logic [WIDE-1:0] c;
        logic [REGW-1:0] rt;
    } stage_t;

    function automatic op_e xo_decode(input logic [XOW-1:0] xo);
        case (xo)
            6'b110000: return OP_HD;
            6'b110001: return OP_HDU;
            6'b110010: return OP_ED;
            6'b110011: return OP_LD;
            default:   return OP_ILL;
        endcase
    endfunction

    function automatic ctl_t op_ctl(input op_e op);
        ctl_t r;
        r = '0;
        case (op)
            OP_HD:   r = '{hi_to_rt: 1'b1, dual: 1'b0, sgn_ab: 1'b1, sgn_c: 1'b1};
            OP_HDU:  r = '{hi_to_rt: 1'b1, dual: 1'b0, sgn_ab: 1'b0, sgn_c: 1'b0};
            OP_ED:   r = '{hi_to_rt: 1'b0, dual: 1'b1, sgn_ab: 1'b0, sgn_c: 1'b0};
            OP_LD:   r = '{hi_to_rt: 1'b0, dual: 1'b0, sgn_ab: 1'b0, sgn_c: 1'b1};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [WIDE-1:0] widen(input logic [XLEN-1:0] v, input logic sgn);
        return sgn ? {{XLEN{v[XLEN-1]}}, v} : {{XLEN{1'b0}}, v};
    endfunction
endpackage

// File: rtl/madd_decode.sv
module madd_decode
    import madd_pkg::*;
(
    input  logic [XOW-1:0] xo,
    output logic           ill,
    output ctl_t           ctl
);
    op_e op;

    always_comb begin
        op  = xo_decode(xo);
        ill = (op == OP_ILL);
        ctl = op_ctl(op);
    end
endmodule

// File: rtl/madd_operand_stage.sv
module madd_operand_stage
    import madd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic            in_ill,
    input  ctl_t            in_ctl,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [XLEN-1:0] in_c,
    input  logic [REGW-1:0] in_rt,
    output stage_t          q
);
    stage_t d;

    always_comb begin
        d.vld = in_vld;
        d.ill = in_ill;
        d.ctl = in_ctl;
        d.a   = widen(in_a, in_ctl.sgn_ab);
        d.b   = widen(in_b, in_ctl.sgn_ab);
        d.c   = widen(in_c, in_ctl.sgn_c);
        d.rt  = in_rt;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/madd_result_stage.sv
module madd_result_stage
    import madd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  stage_t          d,
    output logic            wr_en   [NPORT],
    output logic [REGW-1:0] wr_idx  [NPORT],
    output logic [XLEN-1:0] wr_data [NPORT],
    output logic            ill_q,
    output logic            bad_q
);
    logic [WIDE-1:0] sum;
    logic [XLEN-1:0] lo_half;
    logic [XLEN-1:0] hi_half;
    logic            wrap;
    logic            legal;

    always_comb begin
        sum     = (d.a * d.b) + d.c;
        lo_half = sum[XLEN-1:0];
        hi_half = sum[WIDE-1:XLEN];
        wrap    = d.ctl.dual && (d.rt == {REGW{1'b1}});
        legal   = d.vld && !d.ill && !wrap;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic            en_n;
        logic [REGW-1:0] idx_n;
        logic [XLEN-1:0] data_n;

        always_comb begin
            if (p == 0) begin
                en_n   = legal;
                data_n = d.ctl.hi_to_rt ? hi_half : lo_half;
            end else begin
                en_n   = legal && d.ctl.dual;
                data_n = hi_half;
            end
            idx_n = d.rt + REGW'(p);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                wr_en[p]   <= 1'b0;
                wr_idx[p]  <= '0;
                wr_data[p] <= '0;
            end else begin
                wr_en[p]   <= en_n;
                wr_idx[p]  <= idx_n;
                wr_data[p] <= data_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ill_q <= 1'b0;
            bad_q <= 1'b0;
        end else begin
            ill_q <= d.vld && d.ill;
            bad_q <= d.vld && wrap;
        end
    end
endmodule

// File: rtl/madd_unit.sv
module madd_unit
    import madd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [XOW-1:0]  req_xo,
    input  logic [XLEN-1:0] req_a,
    input  logic [XLEN-1:0] req_b,
    input  logic [XLEN-1:0] req_c,
    input  logic [REGW-1:0] req_rt,
    output logic            wr0_en,
    output logic [REGW-1:0] wr0_idx,
    output logic [XLEN-1:0] wr0_data,
    output logic            wr1_en,
    output logic [REGW-1:0] wr1_idx,
    output logic [XLEN-1:0] wr1_data,
    output logic            illegal,
    output logic            bad_index
);
    logic            dec_ill;
    ctl_t            dec_ctl;
    stage_t          s1;
    logic            en_v   [NPORT];
    logic [REGW-1:0] idx_v  [NPORT];
    logic [XLEN-1:0] data_v [NPORT];

    assign req_ready = !rst;

    madd_decode u_dec (
        .xo  (req_xo),
        .ill (dec_ill),
        .ctl (dec_ctl)
    );

    madd_operand_stage u_ops (
        .clk    (clk),
        .rst    (rst),
        .in_vld (req_valid && req_ready),
        .in_ill (dec_ill),
        .in_ctl (dec_ctl),
        .in_a   (req_a),
        .in_b   (req_b),
        .in_c   (req_c),
        .in_rt  (req_rt),
        .q      (s1)
    );

    madd_result_stage u_res (
        .clk     (clk),
        .rst     (rst),
        .d       (s1),
        .wr_en   (en_v),
        .wr_idx  (idx_v),
        .wr_data (data_v),
        .ill_q   (illegal),
        .bad_q   (bad_index)
    );

    assign wr0_en   = en_v[0];
    assign wr0_idx  = idx_v[0];
    assign wr0_data = data_v[0];
    assign wr1_en   = en_v[1];
    assign wr1_idx  = idx_v[1];
    assign wr1_data = data_v[1];
endmodule

// File: rtl/madd_unit_chk.sv
module madd_unit_chk
    import madd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            wr0_en,
    input logic [REGW-1:0] wr0_idx,
    input logic            wr1_en,
    input logic [REGW-1:0] wr1_idx,
    input logic            illegal,
    input logic            bad_index
);
    logic acc;
    assign acc = req_valid && req_ready;

    // R2
    dual_pair_chk: assert property (@(posedge clk) disable iff (rst)
        wr1_en |-> (wr0_en && wr1_idx == REGW'(wr0_idx + 1'b1) && wr0_idx != {REGW{1'b1}}));

    // R6
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wr0_en && !wr1_en && !bad_index));

    // R7
    wrap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bad_index |-> (!wr0_en && !wr1_en));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $past(acc, 2) |-> (wr0_en || illegal || bad_index));

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(acc, 2) |-> !(wr0_en || wr1_en || illegal || bad_index));

    // R9
    always_comb begin
        if (rst) reset_ready_chk: assert (!req_ready);
    end
endmodule

bind madd_unit madd_unit_chk u_chk (.*);

// File: tb/madd_unit_bench.sv
module madd_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_xo = '0;
    logic [63:0] req_a = '0, req_b = '0, req_c = '0;
    logic [4:0]  req_rt = '0;
    logic        wr0_en, wr1_en, illegal, bad_index;
    logic [4:0]  wr0_idx, wr1_idx;
    logic [63:0] wr0_data, wr1_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    madd_unit u_madd_unit (.*);

    localparam int NV = 12;
    localparam logic [5:0]  VXO [NV] = '{6'b110000, 6'b110000, 6'b110000, 6'b110001,
                                         6'b110001, 6'b110010, 6'b110010, 6'b110010,
                                         6'b110011, 6'b110011, 6'b110000, 6'b110011};
    localparam logic [63:0] VA [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                                        64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
                                        64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
                                        64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF,
                                        64'h0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF};
    localparam logic [63:0] VB [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                                        64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h123,
                                        64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
                                        64'h0FED_CBA9_8765_4321, 64'h2, 64'h0,
                                        64'h7FFF_FFFF_FFFF_FFFF, 64'h1234_5678};
    localparam logic [63:0] VC [NV] = '{64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                                        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
                                        64'hFFFF_FFFF_FFFF_FFFF, 64'h5,
                                        64'hFFFF_0000_FFFF_0000, 64'h8000_0000_0000_0000,
                                        64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                                        64'h0};
    localparam logic [4:0]  VRT [NV] = '{5'd3, 5'd5, 5'd7, 5'd4, 5'd0, 5'd10, 5'd30,
                                         5'd0, 5'd12, 5'd1, 5'd20, 5'd31};

    // Reference model: 128-bit arithmetic formed from the requirement text.
    task automatic ref_model(input logic [5:0] xo, input logic [63:0] a, b, c,
                             input logic [4:0] rt,
                             output logic e0, output logic [4:0] i0, output logic [63:0] d0,
                             output logic e1, output logic [4:0] i1, output logic [63:0] d1);
        logic signed [127:0] sa, sb, sc, ss;
        logic [127:0] ua, ub, uc, us;
        sa = 128'($signed(a)); sb = 128'($signed(b)); sc = 128'($signed(c));
        ua = {64'd0, a}; ub = {64'd0, b}; uc = {64'd0, c};
        ss = sa * sb + sc;
        us = ua * ub + uc;
        e0 = 1'b1; i0 = rt; e1 = 1'b0; i1 = rt + 5'd1; d1 = 64'd0; d0 = 64'd0;
        case (xo)
            6'b110000: d0 = ss[127:64];
            6'b110001: d0 = us[127:64];
            6'b110010: begin d0 = us[63:0]; d1 = us[127:64]; e1 = 1'b1; end
            6'b110011: d0 = 64'(ua * ub + 128'($signed(c)));
            default:   e0 = 1'b0;
        endcase
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [5:0] xo, input logic [63:0] a, b, c, input logic [4:0] rt);
        req_valid = 1'b1; req_xo = xo; req_a = a; req_b = b; req_c = c; req_rt = rt;
    endtask

    task automatic check_result(input string req, input logic [5:0] xo,
                                input logic [63:0] a, b, c, input logic [4:0] rt);
        logic e0, e1; logic [4:0] i0, i1; logic [63:0] d0, d1;
        ref_model(xo, a, b, c, rt, e0, i0, d0, e1, i1, d1);
        chk(req, 64'(wr0_en), 64'(e0));
        chk(req, 64'(wr1_en), 64'(e1));
        if (e0) begin
            chk(req, 64'(wr0_idx), 64'(i0));
            chk(req, wr0_data, d0);
        end
        if (e1) begin
            chk(req, 64'(wr1_idx), 64'(i1));
            chk(req, wr1_data, d1);
        end
    endtask

    function automatic string tag_of(input logic [5:0] xo);
        case (xo)
            6'b110000: return "R5 signed-high (R1)";
            6'b110001: return "R3 unsigned-high (R1)";
            6'b110010: return "R2 dual (R1)";
            default:   return "R4 low (R1)";
        endcase
    endfunction

    initial begin
        // R9: reset state
        @(negedge clk);
        chk("R9 ready in reset", 64'(req_ready), 64'd0);
        chk("R9 enables in reset", 64'({wr0_en, wr1_en, illegal, bad_index}), 64'd0);
        drive(6'b110010, 64'd1, 64'd1, 64'd1, 5'd2);
        @(negedge clk); @(negedge clk);
        chk("R9 no output under reset", 64'({wr0_en, wr1_en, illegal, bad_index}), 64'd0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R9 ready after reset", 64'(req_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            drive(VXO[i], VA[i], VB[i], VC[i], VRT[i]);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8 quiet one edge after accept", 64'({wr0_en, wr1_en}), 64'd0);
            @(negedge clk);
            check_result(tag_of(VXO[i]), VXO[i], VA[i], VB[i], VC[i], VRT[i]);
            chk("R8 no flags on legal op", 64'({illegal, bad_index}), 64'd0);
            @(negedge clk);
            chk("R8 single-cycle pulse", 64'({wr0_en, wr1_en}), 64'd0);
        end

        // R6: reserved and out-of-group selectors
        foreach (VXO[k]) begin end
        for (int s = 0; s < 2; s++) begin
            drive(s == 0 ? 6'b110101 : 6'b000000, 64'd3, 64'd4, 64'd5, 5'd6);
            @(negedge clk); req_valid = 1'b0; @(negedge clk);
            chk("R6 illegal flag", 64'(illegal), 64'd1);
            chk("R6 no writes", 64'({wr0_en, wr1_en}), 64'd0);
            @(negedge clk);
            chk("R6 flag clears", 64'(illegal), 64'd0);
        end

        // R7: dual with wrapping second index
        drive(6'b110010, 64'd9, 64'd9, 64'd9, 5'd31);
        @(negedge clk); req_valid = 1'b0; @(negedge clk);
        chk("R7 bad_index flag", 64'(bad_index), 64'd1);
        chk("R7 no writes", 64'({wr0_en, wr1_en, illegal}), 64'd0);
        @(negedge clk);

        // R10: back-to-back requests
        drive(6'b110010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd7, 5'd8);
        @(negedge clk);
        drive(6'b110001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd7, 5'd9);
        @(negedge clk);
        drive(6'b110000, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 5'd11);
        check_result("R10 first of burst", 6'b110010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd7, 5'd8);
        @(negedge clk);
        req_valid = 1'b0;
        check_result("R10 second of burst", 6'b110001, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd7, 5'd9);
        @(negedge clk);
        check_result("R10 third of burst", 6'b110000, 64'h8000_0000_0000_0000,
                     64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 5'd11);
        @(negedge clk);
        chk("R8 idle after burst", 64'({wr0_en, wr1_en, illegal, bad_index}), 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule